// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI host read and write a register space. The host's serial clock, active-low select and data line are brought into the system clock domain through two-flop synchronizers, so the system clock must run at least eight times faster than the serial clock. The synchronized serial edges then drive a small state machine.

Every transfer begins with a 16-bit instruction word. After the instruction comes a payload of one, two or three bytes, or an open-ended stream. Each payload byte becomes one access on a simple synchronous register-bus master port, which connects to an external register file.

A two-bit configuration register sits inside the port at address zero. It selects the bit order (MSB-first or LSB-first) and the wiring (3-wire shared data pin or 4-wire with a separate output pin).

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, and until a read payload starts, both output enables are low and no bus strobe is issued. The port starts in 3-wire, MSB-first mode.
- R2: Data is sampled on rising serial-clock edges. The 16-bit instruction has bit 15 = read (1) or write (0), bits 14:13 = length code and bits 12:0 = start address.
- R3: Length codes 00, 01 and 10 move exactly 1, 2 and 3 payload bytes. The transfer then ends on its own.
- R4: Length code 11 streams bytes until select is released at a byte boundary. Each completed byte makes exactly one bus access.
- R5: The payload address moves by one per byte. It steps downward in MSB-first mode and upward in LSB-first mode.
- R6: Each completed write byte gives a single-cycle `reg_we_o` pulse carrying that byte's address and data.
- R7: Each read byte gives a single-cycle `reg_re_o` pulse. `reg_rdata_i` is taken one cycle after the pulse. The first bit is presented before the first falling edge, and later bits change only after falling edges.
- R8: In a transfer that is not streaming, select may go high at any byte boundary of the instruction or the payload. The transfer then resumes when select returns low.
- R9: If select goes high in the middle of a byte, the transfer is dropped. The partial byte causes no strobe, and the next transfer starts by decoding a new instruction.
- R10: While select is high, both output enables are low. Read data is driven on `sdio_o` in 3-wire mode and on `sdo_o` in 4-wire mode, and only one enable is ever high.
- R11: Address 0 is the internal configuration byte: bit 0 = LSB-first, bit 1 = 4-wire. Accesses to it never strobe the bus, it reads back as written, and a new setting takes effect from the next transfer.
- R12: In LSB-first mode the instruction is sent bit 0 first, and each data byte is sent bit 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Select, active low |
| sdio_i | input | 1 | Shared data pin, input side |
| sdio_o | output | 1 | Shared data pin, output side |
| sdio_oe_o | output | 1 | Output enable for shared data pin |
| sdo_o | output | 1 | Dedicated read-data output (4-wire) |
| sdo_oe_o | output | 1 | Output enable for dedicated output |
| reg_addr_o | output | 13 | Register bus address |
| reg_wdata_o | output | 8 | Register bus write data |
| reg_we_o | output | 1 | Register bus write strobe |
| reg_re_o | output | 1 | Register bus read strobe |
| reg_rdata_i | input | 8 | Register bus read data, valid one cycle after `reg_re_o` |

## Verification
The hardest cases to reach from the pins are select released at a byte boundary and select released mid-byte. Both depend on where the host stops the clock relative to the byte count inside the slave. The bench's host model can pause select after the eighth instruction bit and after every payload byte, in both writes and reads, and it checks that the outputs are in high impedance during the pause. For the abort cases it sends partial bytes in the instruction and in the payload, then proves the abort by showing that a fresh transfer decodes cleanly. Configuration changes are swept across all four wiring and bit-order combinations with every length code.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LEN_W  = 2;

  typedef enum logic {ST_INSTR, ST_DATA} spi_state_e;

  typedef struct packed {
    logic four_wire;
    logic lsb_first;
  } spi_cfg_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_front.sv
module spi_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic sdio_i,
  output logic rise_o,
  output logic fall_o,
  output logic cs_hi_o,
  output logic din_o
);
  logic [2:0] pin_s;
  logic       sclk_d_q;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_ni, sdio_i}),
    .q_o    (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= pin_s[2];
  end

  assign rise_o  = pin_s[2] & ~sclk_d_q;
  assign fall_o  = ~pin_s[2] & sclk_d_q;
  assign cs_hi_o = pin_s[1];
  assign din_o   = pin_s[0];
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = spi_reg_pkg::ADDR_W,
  parameter int unsigned DATA_W = spi_reg_pkg::DATA_W,
  parameter int unsigned LEN_W  = spi_reg_pkg::LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              cs_hi_i,
  input  logic              din_i,
  output logic              four_wire_o,
  output logic              tx_bit_o,
  output logic              rd_phase_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int unsigned INSTR_W = 1 + LEN_W + ADDR_W;
  localparam int unsigned ICNT_W  = $clog2(INSTR_W);
  localparam int unsigned BCNT_W  = $clog2(DATA_W);

  spi_state_e          state_q;
  logic [ICNT_W-1:0]   ins_cnt_q;
  logic [INSTR_W-1:0]  ins_sr_q, ins_nxt;
  logic [BCNT_W-1:0]   bit_cnt_q;
  logic [DATA_W-1:0]   rx_sr_q, rx_nxt, tx_sr_q, tx_shift, cfg_byte;
  logic                rw_q;
  logic [LEN_W-1:0]    len_q, done_q;
  logic [ADDR_W-1:0]   addr_q, addr_step, bus_addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                we_q, pend_q, pend_cfg_q, ld_q, ld_cfg_q;
  spi_cfg_t            cfg_q, cfg_act_q;
  logic                lsb, idle, mid_byte, stream, last_byte, rd_phase;
  logic [ADDR_W-1:0]   ins_addr;

  assign lsb       = cfg_act_q.lsb_first;
  assign ins_nxt   = lsb ? {din_i, ins_sr_q[INSTR_W-1:1]} : {ins_sr_q[INSTR_W-2:0], din_i};
  assign rx_nxt    = lsb ? {din_i, rx_sr_q[DATA_W-1:1]}   : {rx_sr_q[DATA_W-2:0], din_i};
  assign tx_shift  = lsb ? (tx_sr_q >> 1) : (tx_sr_q << 1);
  assign tx_bit_o  = lsb ? tx_sr_q[0] : tx_sr_q[DATA_W-1];
  assign addr_step = lsb ? addr_q + 1'b1 : addr_q - 1'b1;
  assign ins_addr  = ins_nxt[ADDR_W-1:0];
  assign cfg_byte  = {{(DATA_W-2){1'b0}}, cfg_q};

  assign idle      = (state_q == ST_INSTR) && (ins_cnt_q == '0);
  assign mid_byte  = (state_q == ST_INSTR) ? (ins_cnt_q[BCNT_W-1:0] != '0) : (bit_cnt_q != '0);
  assign stream    = &len_q;
  assign last_byte = !stream && (done_q == len_q);
  assign rd_phase  = (state_q == ST_DATA) && rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_INSTR;
      ins_cnt_q  <= '0;
      ins_sr_q   <= '0;
      bit_cnt_q  <= '0;
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      rw_q       <= 1'b0;
      len_q      <= '0;
      done_q     <= '0;
      addr_q     <= '0;
      bus_addr_q <= '0;
      wdata_q    <= '0;
      we_q       <= 1'b0;
      pend_q     <= 1'b0;
      pend_cfg_q <= 1'b0;
      ld_q       <= 1'b0;
      ld_cfg_q   <= 1'b0;
      cfg_q      <= '0;
      cfg_act_q  <= '0;
    end else begin
      we_q     <= 1'b0;
      pend_q   <= 1'b0;
      ld_q     <= pend_q;
      ld_cfg_q <= pend_cfg_q;
      // settings change only between transfers
      if (idle) cfg_act_q <= cfg_q;

      if (ld_q)
        tx_sr_q <= ld_cfg_q ? cfg_byte : bus_rdata_i;
      else if (fall_i && !cs_hi_i && rd_phase && bit_cnt_q != '0)
        tx_sr_q <= tx_shift;

      if (cs_hi_i) begin
        if (!idle && (mid_byte || (state_q == ST_DATA && stream))) begin
          state_q   <= ST_INSTR;
          ins_cnt_q <= '0;
          bit_cnt_q <= '0;
        end
      end else if (rise_i) begin
        if (state_q == ST_INSTR) begin
          ins_sr_q <= ins_nxt;
          if (ins_cnt_q == ICNT_W'(INSTR_W-1)) begin
            ins_cnt_q <= '0;
            state_q   <= ST_DATA;
            rw_q      <= ins_nxt[INSTR_W-1];
            len_q     <= ins_nxt[INSTR_W-2 -: LEN_W];
            addr_q    <= ins_addr;
            bit_cnt_q <= '0;
            done_q    <= '0;
            if (ins_nxt[INSTR_W-1]) begin
              pend_q     <= 1'b1;
              pend_cfg_q <= (ins_addr == '0);
              bus_addr_q <= ins_addr;
            end
          end else begin
            ins_cnt_q <= ins_cnt_q + 1'b1;
          end
        end else begin
          rx_sr_q   <= rx_nxt;
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == BCNT_W'(DATA_W-1)) begin
            if (!rw_q) begin
              bus_addr_q <= addr_q;
              wdata_q    <= rx_nxt;
              if (addr_q == '0) cfg_q <= spi_cfg_t'(rx_nxt[1:0]);
              else              we_q  <= 1'b1;
            end
            if (last_byte) begin
              state_q <= ST_INSTR;
            end else begin
              addr_q <= addr_step;
              done_q <= done_q + 1'b1;
              if (rw_q) begin
                pend_q     <= 1'b1;
                pend_cfg_q <= (addr_step == '0);
                bus_addr_q <= addr_step;
              end
            end
          end
        end
      end
    end
  end

  assign four_wire_o = cfg_act_q.four_wire;
  assign rd_phase_o  = rd_phase;
  assign bus_addr_o  = bus_addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_we_o    = we_q;
  assign bus_re_o    = pend_q & ~pend_cfg_q;
endmodule

// File: rtl/spi_pad.sv
module spi_pad (
  input  logic cs_ni,
  input  logic rd_phase_i,
  input  logic four_wire_i,
  input  logic tx_bit_i,
  output logic sdio_o,
  output logic sdio_oe_o,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic drive;

  assign drive     = ~cs_ni & rd_phase_i;
  assign sdio_oe_o = drive & ~four_wire_i;
  assign sdo_oe_o  = drive & four_wire_i;
  assign sdio_o    = tx_bit_i;
  assign sdo_o     = tx_bit_i;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int unsigned ADDR_W      = spi_reg_pkg::ADDR_W,
  parameter int unsigned DATA_W      = spi_reg_pkg::DATA_W,
  parameter int unsigned LEN_W       = spi_reg_pkg::LEN_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic rise, fall, cs_hi, din;
  logic four_wire, tx_bit, rd_phase;

  spi_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .cs_ni   (cs_ni),
    .sdio_i  (sdio_i),
    .rise_o  (rise),
    .fall_o  (fall),
    .cs_hi_o (cs_hi),
    .din_o   (din)
  );

  spi_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .fall_i      (fall),
    .cs_hi_i     (cs_hi),
    .din_i       (din),
    .four_wire_o (four_wire),
    .tx_bit_o    (tx_bit),
    .rd_phase_o  (rd_phase),
    .bus_addr_o  (reg_addr_o),
    .bus_wdata_o (reg_wdata_o),
    .bus_we_o    (reg_we_o),
    .bus_re_o    (reg_re_o),
    .bus_rdata_i (reg_rdata_i)
  );

  spi_pad i_pad (
    .cs_ni       (cs_ni),
    .rd_phase_i  (rd_phase),
    .four_wire_i (four_wire),
    .tx_bit_i    (tx_bit),
    .sdio_o      (sdio_o),
    .sdio_oe_o   (sdio_oe_o),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int unsigned ADDR_W = spi_reg_pkg::ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sdio_oe_o,
  input logic              sdo_oe_o,
  input logic              reg_we_o,
  input logic              reg_re_o,
  input logic [ADDR_W-1:0] reg_addr_o
);
  a_r6_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r7_re_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  a_r6_no_we_re_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));

  a_r10_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_o && sdo_oe_o));

  a_r10_hiz_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!sdio_oe_o && !sdo_oe_o));

  a_r11_no_we_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_addr_o != '0));

  a_r11_no_re_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> (reg_addr_o != '0));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .sdio_oe_o  (sdio_oe_o),
  .sdo_oe_o   (sdo_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_re_o   (reg_re_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic sclk = 1'b0, cs_n = 1'b1, sdio_drv = 1'b0;
  logic sdio_o, sdio_oe_o, sdo_o, sdo_oe_o, reg_we, reg_re;
  logic [12:0] reg_addr;
  logic [7:0]  reg_wdata, rdata;

  spi_reg_slave i_spi_reg_slave (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sclk_i      (sclk),
    .cs_ni       (cs_n),
    .sdio_i      (sdio_drv),
    .sdio_o      (sdio_o),
    .sdio_oe_o   (sdio_oe_o),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_re_o    (reg_re),
    .reg_rdata_i (rdata)
  );

  logic [7:0] mem [8192];
  int we_cnt = 0, re_cnt = 0;
  int total = 0, bad = 0;
  bit b_lsb = 0, b_four = 0, rd_mode = 0, stall = 0, rd_oe_ok = 1, hiz_ok = 1;
  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];

  always @(posedge clk) begin
    if (reg_we) begin mem[reg_addr] <= reg_wdata; we_cnt++; end
    if (reg_re) begin rdata <= mem[reg_addr]; re_cnt++; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic clk_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic mo, output logic mi);
    sdio_drv = mo;
    clk_wait(H);
    mi = b_four ? sdo_o : sdio_o;
    if (rd_mode && (b_four ? !(sdo_oe_o && !sdio_oe_o) : !(sdio_oe_o && !sdo_oe_o)))
      rd_oe_ok = 0;
    sclk = 1'b1;
    clk_wait(H);
    sclk = 1'b0;
  endtask

  task automatic byte_xfer(input logic [7:0] mo, output logic [7:0] mi);
    logic b;
    mi = '0;
    for (int i = 0; i < 8; i++) begin
      int k;
      k = b_lsb ? i : 7 - i;
      bit_xfer(mo[k], b);
      mi[k] = b;
    end
  endtask

  task automatic pause();
    clk_wait(H); cs_n = 1'b1; clk_wait(2*H);
    if (sdio_oe_o || sdo_oe_o) hiz_ok = 0;
    clk_wait(H); cs_n = 1'b0; clk_wait(H);
  endtask

  task automatic begin_x();
    clk_wait(2); cs_n = 1'b0; clk_wait(H);
  endtask

  task automatic end_x();
    clk_wait(H); cs_n = 1'b1; clk_wait(4*H);
  endtask

  task automatic send_instr(input logic rw, input logic [1:0] len, input logic [12:0] a);
    logic [15:0] w;
    logic b;
    w = {rw, len, a};
    for (int i = 0; i < 16; i++) begin
      int k;
      k = b_lsb ? i : 15 - i;
      bit_xfer(w[k], b);
      if (stall && i == 7) pause();
    end
  endtask

  task automatic wr_xfer(input logic [12:0] a, input logic [1:0] len, input int n);
    logic [7:0] d;
    begin_x();
    send_instr(1'b0, len, a);
    for (int i = 0; i < n; i++) begin
      byte_xfer(tx_buf[i], d);
      if (stall && i != n - 1) pause();
    end
    end_x();
  endtask

  task automatic rd_xfer(input logic [12:0] a, input logic [1:0] len, input int n);
    logic [7:0] d;
    rd_oe_ok = 1;
    begin_x();
    send_instr(1'b1, len, a);
    rd_mode = 1;
    for (int i = 0; i < n; i++) begin
      byte_xfer(8'h00, d);
      rx_buf[i] = d;
      if (stall && i != n - 1) begin
        rd_mode = 0; pause(); rd_mode = 1;
      end
    end
    rd_mode = 0;
    end_x();
  endtask

  function automatic logic [12:0] step_a(input logic [12:0] b, input int i);
    return b_lsb ? b + 13'(i) : b - 13'(i);
  endfunction

  task automatic set_cfg(input bit four, input bit lsb);
    int w0, r0;
    tx_buf[0] = {6'b0, four, lsb};
    w0 = we_cnt;
    wr_xfer(13'h0000, 2'b00, 1);
    chk("R11 cfg write makes no bus strobe", we_cnt - w0, 0);
    b_four = four;
    b_lsb  = lsb;
    r0 = re_cnt;
    rd_xfer(13'h0000, 2'b00, 1);
    chk("R11 cfg readback", int'(rx_buf[0]), int'({6'b0, four, lsb}));
    chk("R11 cfg read makes no bus strobe", re_cnt - r0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=running exp=finished");
    report();
    $finish;
  end

  initial begin
    int w0, r0, n;
    logic [12:0] base;
    logic b;
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    rdata = 8'h00;
    clk_wait(4);
    chk("R1 reset outputs", int'({sdio_oe_o, sdo_oe_o, reg_we, reg_re}), 0);
    rst_n = 1'b1;
    clk_wait(5);
    chk("R1 idle outputs after reset", int'({sdio_oe_o, sdo_oe_o, reg_we, reg_re}), 0);

    // R2 R3 R6: single byte write, MSB first
    tx_buf[0] = 8'hA5; w0 = we_cnt;
    wr_xfer(13'h0123, 2'b00, 1);
    chk("R2 R6 write data at decoded address", int'(mem[13'h0123]), 'hA5);
    chk("R3 one strobe for code 00", we_cnt - w0, 1);

    // R7 R10: single byte read, 3-wire
    r0 = re_cnt;
    rd_xfer(13'h0123, 2'b00, 1);
    chk("R7 read byte", int'(rx_buf[0]), 'hA5);
    chk("R7 one read strobe", re_cnt - r0, 1);
    chk("R10 sdio driven in 3-wire read", int'(rd_oe_ok), 1);

    // R8: stalls in instruction and payload
    stall = 1; hiz_ok = 1;
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33; w0 = we_cnt;
    wr_xfer(13'h0400, 2'b10, 3);
    chk("R8 stalled write byte0", int'(mem[13'h0400]), 'h11);
    chk("R8 stalled write byte1", int'(mem[13'h03FF]), 'h22);
    chk("R8 stalled write byte2", int'(mem[13'h03FE]), 'h33);
    chk("R8 stalled write strobes", we_cnt - w0, 3);
    rd_xfer(13'h0400, 2'b10, 3);
    chk("R8 stalled read", int'({rx_buf[0], rx_buf[1], rx_buf[2]}), 'h112233);
    chk("R10 high impedance while deselected", int'(hiz_ok), 1);
    stall = 0;

    // R9: abort mid payload byte, then mid instruction
    w0 = we_cnt;
    begin_x();
    send_instr(1'b0, 2'b00, 13'h0500);
    for (int i = 0; i < 3; i++) bit_xfer(1'b1, b);
    end_x();
    chk("R9 partial byte gives no strobe", we_cnt - w0, 0);
    chk("R9 partial byte not stored", int'(mem[13'h0500]), 0);
    begin_x();
    for (int i = 0; i < 5; i++) bit_xfer(1'b1, b);
    end_x();
    tx_buf[0] = 8'h3C; w0 = we_cnt;
    wr_xfer(13'h0500, 2'b00, 1);
    chk("R9 fresh instruction after abort", int'(mem[13'h0500]), 'h3C);
    chk("R9 single strobe after abort", we_cnt - w0, 1);

    // sweep of wiring, bit order and length codes
    for (int four = 0; four < 2; four++) begin
      for (int lsb = 0; lsb < 2; lsb++) begin
        set_cfg(bit'(four), bit'(lsb));
        for (int len = 0; len < 4; len++) begin
          n = (len == 3) ? 5 : len + 1;
          base = 13'h0800 + 13'((four * 8 + lsb * 4 + len) * 16);
          for (int i = 0; i < n; i++)
            tx_buf[i] = 8'((four << 7) ^ (lsb << 6) ^ (len << 4) ^ (i * 7 + 1));
          w0 = we_cnt;
          wr_xfer(base, 2'(len), n);
          chk($sformatf("%s strobe count four=%0d lsb=%0d len=%0d",
                        (len == 3) ? "R4" : "R3", four, lsb, len), we_cnt - w0, n);
          for (int i = 0; i < n; i++)
            chk($sformatf("R5 %s stored four=%0d lsb=%0d len=%0d i=%0d",
                          lsb ? "R12" : "R2", four, lsb, len, i),
                int'(mem[step_a(base, i)]), int'(tx_buf[i]));
          r0 = re_cnt;
          rd_xfer(base, 2'(len), n);
          for (int i = 0; i < n; i++)
            chk($sformatf("R7 %s read four=%0d lsb=%0d len=%0d i=%0d",
                          lsb ? "R12" : "R2", four, lsb, len, i),
                int'(rx_buf[i]), int'(tx_buf[i]));
          if (len < 3)
            chk($sformatf("R7 read strobes len=%0d", len), re_cnt - r0, n);
          chk($sformatf("R10 driver select four=%0d", four), int'(rd_oe_ok), 1);
        end
      end
    end

    set_cfg(1'b0, 1'b0);
    chk("R1 R10 idle enables at end", int'({sdio_oe_o, sdo_oe_o}), 0);
    report();
    $finish;
  end
endmodule